// File: doc/BRIEF.md
# Tile Configuration Register Bank

Each tile in an array sits on one shared configuration bus and keeps a small bank of 32-bit registers that hold its settings. Every bus address carries three fields: the coordinate of the tile it targets and the index of a register inside that tile. The tile compares the coordinate field with its own coordinate, which is fixed when it is built. When the two match, a write strobe stores the bus data in the indexed register at the next rising clock edge. A read strobe puts the indexed register on the read-data output in the same cycle.

When the tile is not addressed, the read-data output is zero. A system can therefore OR the read outputs of all tiles into one return bus with no extra multiplexing. A synchronous active-high reset sets every register to zero. After reset the bank is fully usable again: a new configuration can be written and read back at once.

Top module: `tile_cfg_bank`

## Requirements
- R1: A tile is selected only when address bits 15:8 equal its X coordinate and address bits 7:0 equal its Y coordinate. The default coordinate is X=3, Y=5.
- R2: When the tile is selected and the write strobe is high, the register named by address bits 31:24 takes the write data at the next rising clock edge. No other register changes.
- R3: While the read strobe is high and the tile is selected, the read-data output shows the indexed register in the same cycle. A read that follows a write to the same address returns exactly the value written.
- R4: A synchronous active-high reset zeroes every register. After reset, a read of any register returns zero.
- R5: After a reset, new writes are accepted, and readback matches the new values.
- R6: A write whose coordinate field does not match leaves every register unchanged. A read whose coordinate field does not match returns zero.
- R7: While the read strobe is low, the read-data output is zero, whatever the address.
- R8: Address bits 23:16 have no effect on selection, on the register a write reaches, or on the value a read returns.
- R9: A register index at or above the bank size (8 by default) reaches no register. Such a write changes nothing, and such a read returns zero.
- R10: A reset in the same cycle as a write wins: the register ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 32 | Bus address: index [31:24], unused [23:16], X [15:8], Y [7:0] |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe, never high together with cfg_wr |
| cfg_rdata | output | 32 | Read data, zero when the tile is not selected or no read is requested |

## Verification
Some write errors cannot be seen in the register the write targets: a write that lands in a neighbouring register, reaches a tile it should miss, or takes effect while reset is high. Each of these shows up only on a later read of some other register, so the stimulus first fills all eight registers with distinct values. It then sends writes that carry a wrong X field, a wrong Y field, an out-of-range index, and noise in bits 23:16, and it sends one write during reset. After each of these disturbances it sweeps reads over the whole bank. A reference model, updated on every clock, predicts the read data for every cycle, including the cycles in which no read is requested.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int CFG_AW  = 32;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] idx;
    logic [FIELD_W-1:0] spare;
    logic [FIELD_W-1:0] x;
    logic [FIELD_W-1:0] y;
  } cfg_addr_t;

  function automatic logic [15:0] tile_id(input logic [7:0] x, input logic [7:0] y);
    return {x, y};
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgbank_pkg::*;
#(
  parameter int TILE_X   = 3,
  parameter int TILE_Y   = 5,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [CFG_AW-1:0] addr,
  input  logic              wr,
  output logic              tile_hit,
  output logic              idx_ok,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [NUM_REGS-1:0] wen
);
  cfg_addr_t a;
  assign a = cfg_addr_t'(addr);

  localparam logic [15:0] MY_ID = tile_id(TILE_X[7:0], TILE_Y[7:0]);

  assign tile_hit = (tile_id(a.x, a.y) == MY_ID);
  assign idx_ok   = ({24'b0, a.idx} < 32'(NUM_REGS));
  assign sel_idx  = a.idx[IDX_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
    assign wen[i] = wr && tile_hit && (a.idx == FIELD_W'(i));
  end
endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] wen,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   regs [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wen[i])
        regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              rd,
  input  logic              tile_hit,
  input  logic              idx_ok,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd && tile_hit && idx_ok)
      rdata = regs[sel_idx];
  end
endmodule

// File: rtl/tile_cfg_bank.sv
module tile_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int TILE_X   = 3,
  parameter int TILE_Y   = 5,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic                tile_hit;
  logic                idx_ok;
  logic [IDX_W-1:0]    sel_idx;
  logic [NUM_REGS-1:0] wen;
  logic [DATA_W-1:0]   regs [NUM_REGS];

  cfg_addr_decode #(
    .TILE_X(TILE_X), .TILE_Y(TILE_Y), .NUM_REGS(NUM_REGS)
  ) u_dec (
    .addr(cfg_addr), .wr(cfg_wr), .tile_hit(tile_hit),
    .idx_ok(idx_ok), .sel_idx(sel_idx), .wen(wen)
  );

  cfg_reg_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wen(wen), .wdata(cfg_wdata), .regs(regs)
  );

  cfg_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rmux (
    .rd(cfg_rd), .tile_hit(tile_hit), .idx_ok(idx_ok),
    .sel_idx(sel_idx), .regs(regs), .rdata(cfg_rdata)
  );
endmodule

// File: rtl/tile_cfg_bank_chk.sv
module tile_cfg_bank_chk #(
  parameter int TILE_X   = 3,
  parameter int TILE_Y   = 5,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [DATA_W-1:0] cfg_rdata
);
  logic here, in_range, past_valid;
  assign here     = (cfg_addr[15:8] == TILE_X[7:0]) && (cfg_addr[7:0] == TILE_Y[7:0]);
  assign in_range = ({24'b0, cfg_addr[31:24]} < 32'(NUM_REGS));

  always_ff @(posedge clk) past_valid <= 1'b1;

  // R7
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |-> cfg_rdata == '0);
  // R6
  other_tile_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !here |-> cfg_rdata == '0);
  // R9
  bad_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> cfg_rdata == '0);
  // R4
  post_reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(rst)) |-> cfg_rdata == '0);
  // R3 and R8: read after a write to the same index and tile returns the written data
  write_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst) && $past(cfg_wr && here && in_range) && cfg_rd
     && cfg_addr[31:24] == $past(cfg_addr[31:24]) && cfg_addr[15:0] == $past(cfg_addr[15:0]))
    |-> cfg_rdata == $past(cfg_wdata));
  // R2
  hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && !$past(rst) && !$past(cfg_wr) && $past(cfg_rd) && cfg_rd
     && cfg_addr == $past(cfg_addr)) |-> $stable(cfg_rdata));
endmodule

bind tile_cfg_bank tile_cfg_bank_chk #(
  .TILE_X(TILE_X), .TILE_Y(TILE_Y), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
);

// File: tb/tile_cfg_bank_test.sv
module tile_cfg_bank_test;
  localparam int NREG = 8;
  localparam logic [7:0] MX = 8'd3;
  localparam logic [7:0] MY = 8'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [31:0] cfg_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [NREG];

  always #2 clk = ~clk;

  tile_cfg_bank uut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
    end else if (cfg_wr && cfg_addr[15:8] == MX && cfg_addr[7:0] == MY
                 && cfg_addr[31:24] < NREG) begin
      model[cfg_addr[26:24]] = cfg_wdata;
    end
  end

  function automatic logic [31:0] mk(input logic [7:0] idx, input logic [7:0] x,
                                     input logic [7:0] y, input logic [7:0] sp = 8'h00);
    return {idx, sp, x, y};
  endfunction

  // one bus cycle: drive after the falling edge, compare, then wait for the next falling edge
  task automatic cyc(input logic w, input logic r, input logic [31:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] exp;
    cfg_wr = w; cfg_rd = r; cfg_addr = a; cfg_wdata = d;
    #1;
    exp = '0;
    if (r && a[15:8] == MX && a[7:0] == MY && a[31:24] < NREG) exp = model[a[26:24]];
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, cfg_rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NREG; i++) cyc(0, 1, mk(8'(i), MX, MY), 32'h0, tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    cyc(0, 1, mk(0, MX, MY), 0, "R4 reset read");
    rst = 0;
    sweep("R4 initial zero");
    // R2 fill bank with distinct values, R3 readback
    for (int i = 0; i < NREG; i++) cyc(1, 0, mk(8'(i), MX, MY), 32'hA5000000 + 32'(i*17), "R2 write");
    sweep("R3 readback");
    cyc(1, 0, mk(2, MX, MY), 32'hDEADBEEF, "R2 overwrite");
    cyc(0, 1, mk(2, MX, MY), 0, "R3 immediate readback");
    // R7 idle read data
    cyc(0, 0, mk(2, MX, MY), 0, "R7 no strobe");
    cyc(0, 0, mk(1, MX, MY), 0, "R7 no strobe");
    // R1/R6 other tiles
    cyc(1, 0, mk(3, MX + 1, MY), 32'h11111111, "R6 wrong X write");
    cyc(1, 0, mk(4, MX, MY + 1), 32'h22222222, "R6 wrong Y write");
    cyc(1, 0, mk(5, MY, MX), 32'h33333333, "R1 swapped coord write");
    cyc(0, 1, mk(3, MX + 1, MY), 0, "R6 wrong X read");
    cyc(0, 1, mk(4, MX, MY + 1), 0, "R6 wrong Y read");
    sweep("R6 bank untouched");
    // R8 ignored bits
    cyc(1, 0, mk(6, MX, MY, 8'hFF), 32'h0BADF00D, "R8 write with noise");
    cyc(0, 1, mk(6, MX, MY, 8'h5A), 0, "R8 read with noise");
    sweep("R8 bank");
    // R9 index out of range
    cyc(1, 0, mk(8, MX, MY), 32'h77777777, "R9 write idx 8");
    cyc(1, 0, mk(8'hFF, MX, MY), 32'h88888888, "R9 write idx 255");
    cyc(0, 1, mk(8, MX, MY), 0, "R9 read idx 8");
    cyc(0, 1, mk(8'h80, MX, MY), 0, "R9 read idx 128");
    sweep("R9 bank untouched");
    // R10 reset together with a write
    rst = 1;
    cyc(1, 0, mk(1, MX, MY), 32'h12345678, "R10 write in reset");
    rst = 0;
    sweep("R4 R10 zero after reset");
    // R5 reconfigure
    for (int i = NREG - 1; i >= 0; i--) cyc(1, 0, mk(8'(i), MX, MY), 32'h5A5A0000 ^ 32'(i << 4), "R5 rewrite");
    sweep("R5 readback");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule